// File: doc/BRIEF.md
# Sector protection command decoder

This block sits on the write side of a parallel flash-style bus. It watches every write strobe, with its address and 8-bit data. It tracks the unlock prefix and the mode-entry codes. Inside a mode, it decodes the commands that set, clear or query protection for each sector. Protection state lives in registers:

- a volatile bit for each sector;
- a persistent-style bit for each sector;
- a global lock bit that freezes the persistent bits once it is set.

A sector counts as protected when either of its two bits is set. The block exports one protected flag per sector. Any write that arrives out of sequence or carries a wrong value puts the decoder in a fault state. A reset command takes it out of that state.

A system uses the block as follows. It writes the unlock prefix and a mode code. It then issues program or clear commands, or strobes a status read for a sector. It leaves the mode with the two-write exit sequence. Commands that set a bit take effect only while the accelerate input is high. Status reads report the queried bit on data bit 0, and the value appears on the read data port one clock after the read strobe.

Top module: `sector_guard_decoder`

## Requirements
- R1: Mode entry takes three writes: AA to command address 555, then 55 to command address 2AA, then a mode code to 555. The accepted codes are E0 (volatile bits), C0 (persistent bits), 50 (global lock), 40 (lock register) and 60 (password). Any other code, or a wrong address, faults.
- R2: In any mode, 90 followed by 00, each written to any address, returns the block to read mode. In read mode, a status read returns 00.
- R3: In volatile mode, A0 followed by a write of 00 to a sector address sets that sector's volatile bit. A0 followed by 01 clears it. Clearing does not depend on the accelerate input.
- R4: In persistent mode, A0 followed by a write of 00 to a sector address sets that sector's persistent bit.
- R5: In persistent mode, 80 followed by 30 written to command address 0 clears every persistent bit.
- R6: In global-lock mode, A0 followed by 00 to any address sets the lock. While the lock is set, persistent program and clear-all commands change nothing. Only a hardware reset clears the lock.
- R7: A status read strobed while in a mode places the indicator on rd_data bit 0 one clock later: 0 means protected, 1 means unprotected, and bits 7..1 are zero. Volatile mode reports the volatile bit of the sector, persistent mode reports the persistent bit, and global-lock mode reports the lock. A read outside a mode, in a lock-register or password mode, or in the middle of a command returns 00.
- R8: A write with the wrong data, the wrong address or out of order sets seq_fault. seq_fault stays set through any later write other than F0. In the lock-register and password modes, only the exit sequence is valid.
- R9: A write of F0 to any address returns the block to read mode from every state, including the fault state, and leaves every protection bit unchanged.
- R10: A set command, volatile or persistent, has no effect unless accel is high in the cycle of its final write.
- R11: Command matching compares only address bits 10..0. The sector index is address bits 11..9. Address bits not named in a command are ignored.
- R12: sector_protected[i] is the OR of sector i's volatile and persistent bits. It changes one clock after the final write of a command.
- R13: After a hardware reset, every protection bit and the lock are clear, seq_fault is low, rd_data is 00 and the block is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| accel | input | 1 | Accelerate level; must be high for set commands |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address; low CMD_AW bits for commands, top bits select the sector |
| wr_data | input | 8 | Write data (command code) |
| rd_en | input | 1 | Status read strobe |
| rd_sector | input | SECT_W | Sector queried by a status read |
| rd_data | output | 8 | Status read result, indicator on bit 0 |
| sector_protected | output | NUM_SECT | Per-sector protected flag |
| seq_fault | output | 1 | Decoder is in the fault state |

## Verification
Each write is registered once. A command's effect on sector_protected and seq_fault therefore appears at the first rising edge that samples its final write. A status read lands on rd_data at the rising edge that samples rd_en. The bench drives inputs on the falling edge and compares all three outputs with its behavioural model on every following falling edge. The model updates on the same rising edge as the design. The directed checks are placed right after the write or read task returns, which is exactly one edge after the strobe.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] CMD_UNLOCK_A  = 8'hAA;
  localparam logic [CODE_W-1:0] CMD_UNLOCK_B  = 8'h55;
  localparam logic [CODE_W-1:0] CMD_RESET     = 8'hF0;
  localparam logic [CODE_W-1:0] CMD_EXIT_A    = 8'h90;
  localparam logic [CODE_W-1:0] CMD_EXIT_B    = 8'h00;
  localparam logic [CODE_W-1:0] CMD_ARM_PROG  = 8'hA0;
  localparam logic [CODE_W-1:0] CMD_ARM_ERASE = 8'h80;
  localparam logic [CODE_W-1:0] CMD_ERASE_GO  = 8'h30;
  localparam logic [CODE_W-1:0] DAT_SET       = 8'h00;
  localparam logic [CODE_W-1:0] DAT_CLR       = 8'h01;

  localparam logic [CODE_W-1:0] ENT_VOL     = 8'hE0;
  localparam logic [CODE_W-1:0] ENT_PERS    = 8'hC0;
  localparam logic [CODE_W-1:0] ENT_GLOCK   = 8'h50;
  localparam logic [CODE_W-1:0] ENT_LOCKREG = 8'h40;
  localparam logic [CODE_W-1:0] ENT_PASSWD  = 8'h60;

  typedef enum logic [2:0] {
    ST_READ, ST_UNLK1, ST_UNLK2, ST_MODE, ST_ARM_PROG, ST_ARM_ERASE, ST_EXIT1, ST_FAULT
  } seq_state_e;

  typedef enum logic [2:0] {
    MD_NONE, MD_VOL, MD_PERS, MD_GLOCK, MD_LOCKREG, MD_PASSWD
  } mode_e;

  typedef struct packed {
    logic set_vol;
    logic clr_vol;
    logic set_pers;
    logic clr_all;
    logic set_glock;
  } prot_act_t;

  function automatic mode_e mode_from_code(input logic [CODE_W-1:0] c);
    mode_e m;
    case (c)
      ENT_VOL:     m = MD_VOL;
      ENT_PERS:    m = MD_PERS;
      ENT_GLOCK:   m = MD_GLOCK;
      ENT_LOCKREG: m = MD_LOCKREG;
      ENT_PASSWD:  m = MD_PASSWD;
      default:     m = MD_NONE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sg_cmd_fsm.sv
module sg_cmd_fsm
  import sg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CMD_AW = 11,
  parameter int SECT_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CODE_W-1:0]   wr_data,
  output seq_state_e          state_o,
  output mode_e               mode_o,
  output prot_act_t           act_o,
  output logic [SECT_W-1:0]   act_sect_o
);
  localparam logic [CMD_AW-1:0] ADR_555  = CMD_AW'('h555);
  localparam logic [CMD_AW-1:0] ADR_2AA  = CMD_AW'('h2AA);
  localparam logic [CMD_AW-1:0] ADR_ZERO = '0;

  seq_state_e state_q, state_d;
  mode_e      mode_q, mode_d;
  prot_act_t  act_d;
  logic       bad;
  mode_e      ent_mode;

  logic [CMD_AW-1:0] cmd_addr;
  logic at_555, at_2aa, at_zero;

  assign cmd_addr   = wr_addr[CMD_AW-1:0];
  assign at_555     = (cmd_addr == ADR_555);
  assign at_2aa     = (cmd_addr == ADR_2AA);
  assign at_zero    = (cmd_addr == ADR_ZERO);
  assign ent_mode   = mode_from_code(wr_data);
  assign act_sect_o = wr_addr[ADDR_W-1 -: SECT_W];

  // next-state decode
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    act_d   = '0;
    bad     = 1'b0;
    if (wr_data == CMD_RESET) begin
      state_d = ST_READ;
      mode_d  = MD_NONE;
    end else begin
      case (state_q)
        ST_READ: begin
          if (at_555 && wr_data == CMD_UNLOCK_A) state_d = ST_UNLK1;
          else bad = 1'b1;
        end
        ST_UNLK1: begin
          if (at_2aa && wr_data == CMD_UNLOCK_B) state_d = ST_UNLK2;
          else bad = 1'b1;
        end
        ST_UNLK2: begin
          if (at_555 && ent_mode != MD_NONE) begin
            state_d = ST_MODE;
            mode_d  = ent_mode;
          end else bad = 1'b1;
        end
        ST_MODE: begin
          if (wr_data == CMD_EXIT_A) state_d = ST_EXIT1;
          else if (wr_data == CMD_ARM_PROG &&
                   (mode_q == MD_VOL || mode_q == MD_PERS || mode_q == MD_GLOCK))
            state_d = ST_ARM_PROG;
          else if (wr_data == CMD_ARM_ERASE && mode_q == MD_PERS)
            state_d = ST_ARM_ERASE;
          else bad = 1'b1;
        end
        ST_ARM_PROG: begin
          state_d = ST_MODE;
          if (mode_q == MD_VOL && wr_data == DAT_SET)        act_d.set_vol   = 1'b1;
          else if (mode_q == MD_VOL && wr_data == DAT_CLR)   act_d.clr_vol   = 1'b1;
          else if (mode_q == MD_PERS && wr_data == DAT_SET)  act_d.set_pers  = 1'b1;
          else if (mode_q == MD_GLOCK && wr_data == DAT_SET) act_d.set_glock = 1'b1;
          else bad = 1'b1;
        end
        ST_ARM_ERASE: begin
          if (at_zero && wr_data == CMD_ERASE_GO) begin
            state_d       = ST_MODE;
            act_d.clr_all = 1'b1;
          end else bad = 1'b1;
        end
        ST_EXIT1: begin
          if (wr_data == CMD_EXIT_B) begin
            state_d = ST_READ;
            mode_d  = MD_NONE;
          end else bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
      if (bad) begin
        state_d = ST_FAULT;
        mode_d  = MD_NONE;
        act_d   = '0;
      end
    end
  end

  // state register, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      mode_q  <= MD_NONE;
    end else if (wr_en) begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign act_o   = wr_en ? act_d : '0;

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && !(wr_en && wr_data == CMD_RESET)) |=> (state_q == ST_FAULT)); // R8
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == CMD_RESET) |=> (state_q == ST_READ && mode_q == MD_NONE)); // R9
  AST_ACT_BACK_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o != '0) |=> (state_q == ST_MODE)); // R3
  AST_READ_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ) |-> (mode_q == MD_NONE)); // R2
endmodule

// File: rtl/sg_prot_bank.sv
module sg_prot_bank
  import sg_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accel_i,
  input  prot_act_t           act_i,
  input  logic [SECT_W-1:0]   sect_i,
  output logic [NUM_SECT-1:0] vol_o,
  output logic [NUM_SECT-1:0] pers_o,
  output logic                glock_o,
  output logic [NUM_SECT-1:0] prot_o
);
  logic [NUM_SECT-1:0] vol_q, pers_q;
  logic [NUM_SECT-1:0] vol_en, vol_nx, pers_en, pers_nx;
  logic                glock_q;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    logic sel;
    assign sel        = (sect_i == SECT_W'(g));
    assign vol_en[g]  = sel && ((act_i.set_vol && accel_i) || act_i.clr_vol);
    assign vol_nx[g]  = act_i.set_vol;
    assign pers_en[g] = !glock_q &&
                        (act_i.clr_all || (act_i.set_pers && sel && accel_i));
    assign pers_nx[g] = !act_i.clr_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q  <= '0;
      pers_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SECT; i++) begin
        if (vol_en[i])  vol_q[i]  <= vol_nx[i];
        if (pers_en[i]) pers_q[i] <= pers_nx[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               glock_q <= 1'b0;
    else if (act_i.set_glock) glock_q <= 1'b1;
  end

  assign vol_o   = vol_q;
  assign pers_o  = pers_q;
  assign glock_o = glock_q;
  assign prot_o  = vol_q | pers_q;

  AST_GLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    glock_q |=> glock_q); // R6
  AST_PERS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    glock_q |=> $stable(pers_q)); // R6
  AST_VOL_NO_SET_NOACCEL: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_i |=> ((vol_q & ~$past(vol_q)) == '0)); // R10
  AST_PERS_NO_SET_NOACCEL: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_i |=> ((pers_q & ~$past(pers_q)) == '0)); // R10
endmodule

// File: rtl/sg_status_port.sv
module sg_status_port
  import sg_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [SECT_W-1:0]   rd_sector,
  input  seq_state_e          state_i,
  input  mode_e               mode_i,
  input  logic [NUM_SECT-1:0] vol_i,
  input  logic [NUM_SECT-1:0] pers_i,
  input  logic                glock_i,
  output logic [CODE_W-1:0]   rd_data
);
  logic              vbit, pbit;
  logic [CODE_W-1:0] rd_d, rd_q;

  always_comb begin
    vbit = 1'b0;
    pbit = 1'b0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (rd_sector == SECT_W'(i)) begin
        vbit = vol_i[i];
        pbit = pers_i[i];
      end
    end
    rd_d = '0;
    if (state_i == ST_MODE) begin
      case (mode_i)
        MD_VOL:   rd_d[0] = ~vbit;
        MD_PERS:  rd_d[0] = ~pbit;
        MD_GLOCK: rd_d[0] = ~glock_i;
        default:  rd_d    = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state_i != ST_MODE) |=> (rd_data == '0)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R7
endmodule

// File: rtl/sector_guard_decoder.sv
module sector_guard_decoder
  import sg_pkg::*;
#(
  parameter  int NUM_SECT = 8,
  parameter  int ADDR_W   = 12,
  parameter  int CMD_AW   = 11,
  localparam int SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accel,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                rd_en,
  input  logic [SECT_W-1:0]   rd_sector,
  output logic [7:0]          rd_data,
  output logic [NUM_SECT-1:0] sector_protected,
  output logic                seq_fault
);
  logic rst_meta, rst_sync;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  seq_state_e          state;
  mode_e               mode;
  prot_act_t           act;
  logic [SECT_W-1:0]   act_sect;
  logic [NUM_SECT-1:0] vol, pers;
  logic                glock;

  sg_cmd_fsm #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW), .SECT_W(SECT_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .state_o(state), .mode_o(mode), .act_o(act), .act_sect_o(act_sect)
  );

  sg_prot_bank #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_bank (
    .clk(clk), .rst_n(rst_sync), .accel_i(accel), .act_i(act), .sect_i(act_sect),
    .vol_o(vol), .pers_o(pers), .glock_o(glock), .prot_o(sector_protected)
  );

  sg_status_port #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_stat (
    .clk(clk), .rst_n(rst_sync), .rd_en(rd_en), .rd_sector(rd_sector),
    .state_i(state), .mode_i(mode), .vol_i(vol), .pers_i(pers), .glock_i(glock),
    .rd_data(rd_data)
  );

  assign seq_fault = (state == ST_FAULT);
endmodule

// File: tb/sector_guard_decoder_tb_top.sv
`timescale 1ns/1ps
module sector_guard_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accel = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_sector = '0;
  logic [7:0]  rd_data;
  logic [7:0]  sector_protected;
  logic        seq_fault;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sector_guard_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .accel(accel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sector(rd_sector), .rd_data(rd_data),
    .sector_protected(sector_protected), .seq_fault(seq_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: state 0 read,1/2 unlock,3 mode,4 arm-prog,5 arm-erase,6 exit,7 fault
  int         m_state;
  logic [7:0] m_mode;
  logic [7:0] m_vol, m_pers, m_rd;
  logic       m_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_mode = 8'h00; m_vol = '0; m_pers = '0; m_lock = 1'b0; m_rd = '0;
    end else begin
      if (rd_en) begin
        m_rd = 8'h00;
        if (m_state == 3 && m_mode == 8'hE0) m_rd[0] = !m_vol[rd_sector];
        if (m_state == 3 && m_mode == 8'hC0) m_rd[0] = !m_pers[rd_sector];
        if (m_state == 3 && m_mode == 8'h50) m_rd[0] = !m_lock;
      end
      if (wr_en) begin
        automatic logic [7:0]  d = wr_data;
        automatic logic [10:0] a = wr_addr[10:0];
        automatic int          s = int'(wr_addr[11:9]);
        if (d == 8'hF0) begin m_state = 0; m_mode = 8'h00; end
        else if (m_state == 0) m_state = (a == 11'h555 && d == 8'hAA) ? 1 : 7;
        else if (m_state == 1) m_state = (a == 11'h2AA && d == 8'h55) ? 2 : 7;
        else if (m_state == 2) begin
          if (a == 11'h555 && (d == 8'hE0 || d == 8'hC0 || d == 8'h50 || d == 8'h40 || d == 8'h60)) begin
            m_state = 3; m_mode = d;
          end else m_state = 7;
        end else if (m_state == 3) begin
          if (d == 8'h90) m_state = 6;
          else if (d == 8'hA0 && (m_mode == 8'hE0 || m_mode == 8'hC0 || m_mode == 8'h50)) m_state = 4;
          else if (d == 8'h80 && m_mode == 8'hC0) m_state = 5;
          else m_state = 7;
        end else if (m_state == 4) begin
          m_state = 3;
          if (m_mode == 8'hE0 && d == 8'h00) begin if (accel) m_vol[s] = 1'b1; end
          else if (m_mode == 8'hE0 && d == 8'h01) m_vol[s] = 1'b0;
          else if (m_mode == 8'hC0 && d == 8'h00) begin if (accel && !m_lock) m_pers[s] = 1'b1; end
          else if (m_mode == 8'h50 && d == 8'h00) m_lock = 1'b1;
          else m_state = 7;
        end else if (m_state == 5) begin
          if (a == 11'h000 && d == 8'h30) begin
            m_state = 3;
            if (!m_lock) m_pers = '0;
          end else m_state = 7;
        end else if (m_state == 6) begin
          if (d == 8'h00) begin m_state = 0; m_mode = 8'h00; end
          else m_state = 7;
        end
        if (m_state == 7) m_mode = 8'h00;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 sector_protected vs model", int'(sector_protected), int'(m_vol | m_pers));
      chk("R8 seq_fault vs model", int'(seq_fault), (m_state == 7) ? 1 : 0);
      chk("R7 rd_data vs model", int'(rd_data), int'(m_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [11:0] sa(input int s, input logic [8:0] low);
    return {s[2:0], low};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int s);
    @(negedge clk);
    rd_en = 1'b1; rd_sector = s[2:0];
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic enter(input logic [7:0] code);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, code);
  endtask

  task automatic leave();
    wr(12'h3A7, 8'h90); wr(12'h0F1, 8'h00);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    hw_reset();
    chk("R13 protected after reset", int'(sector_protected), 0);
    chk("R13 fault after reset", int'(seq_fault), 0);
    chk("R13 rd_data after reset", int'(rd_data), 0);

    enter(8'hE0);
    rd(2); chk("R1 volatile mode entered, sector 2 unprotected", int'(rd_data), 1);
    accel = 1'b0;
    wr(12'h000, 8'hA0); wr(sa(2, 9'h123), 8'h00);
    chk("R10 volatile set ignored without accel", int'(sector_protected), 0);
    accel = 1'b1;
    wr(12'h000, 8'hA0); wr(sa(2, 9'h1FF), 8'h00);
    chk("R3 volatile set sector 2", int'(sector_protected), 8'h04);
    rd(2); chk("R7 read protected sector", int'(rd_data), 0);
    rd(3); chk("R7 read unprotected sector", int'(rd_data), 1);
    wr(12'h000, 8'hA0); wr(sa(7, 9'h000), 8'h00);
    accel = 1'b0;
    wr(12'h000, 8'hA0); wr(sa(2, 9'h055), 8'h01);
    chk("R3 volatile clear without accel", int'(sector_protected), 8'h80);
    leave();
    chk("R2 exit leaves no fault", int'(seq_fault), 0);
    rd(7); chk("R2 read in read mode gives 00", int'(rd_data), 0);

    enter(8'h00); wr(12'hF0F, 8'hF0);
    wr(12'hD55, 8'hAA); wr(12'hAAA, 8'h55); wr(12'hD55, 8'hC0);
    chk("R11 entry with high address bits set", int'(seq_fault), 0);
    accel = 1'b1;
    wr(12'h000, 8'hA0); wr(sa(1, 9'h000), 8'h00);
    wr(12'h000, 8'hA0); wr(sa(5, 9'h1AA), 8'h00);
    chk("R4 persistent set sectors 1 and 5", int'(sector_protected), 8'hA2);
    rd(5); chk("R7 persistent read protected", int'(rd_data), 0);
    rd(7); chk("R7 persistent read ignores volatile bit", int'(rd_data), 1);
    wr(12'h000, 8'h80); wr(12'h800, 8'h30);
    chk("R5 clear-all persistent", int'(sector_protected), 8'h80);
    wr(12'h000, 8'hA0); wr(sa(3, 9'h000), 8'h00);
    chk("R4 persistent set sector 3", int'(sector_protected), 8'h88);
    leave();

    enter(8'h50);
    rd(0); chk("R6 lock initially clear", int'(rd_data), 1);
    wr(12'h3C4, 8'hA0); wr(12'h7E1, 8'h00);
    rd(4); chk("R6 lock set", int'(rd_data), 0);
    leave();
    enter(8'hC0);
    wr(12'h000, 8'hA0); wr(sa(6, 9'h000), 8'h00);
    chk("R6 persistent set frozen by lock", int'(sector_protected), 8'h88);
    wr(12'h000, 8'h80); wr(12'h000, 8'h30);
    chk("R6 clear-all frozen by lock", int'(sector_protected), 8'h88);
    leave();

    wr(12'h555, 8'h12);
    chk("R8 bad data in read mode faults", int'(seq_fault), 1);
    wr(12'h555, 8'hAA);
    chk("R8 fault holds through valid-looking write", int'(seq_fault), 1);
    rd(3); chk("R7 read in fault gives 00", int'(rd_data), 0);
    wr(12'h123, 8'hF0);
    chk("R9 reset command clears fault", int'(seq_fault), 0);
    chk("R9 reset command keeps protection", int'(sector_protected), 8'h88);

    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h000, 8'hF0);
    chk("R9 reset mid-prefix no fault", int'(seq_fault), 0);
    wr(12'h2AA, 8'h55);
    chk("R8 out-of-order prefix faults", int'(seq_fault), 1);
    wr(12'h000, 8'hF0);
    enter(8'h40); wr(12'h000, 8'hA0);
    chk("R8 program in lock-register mode faults", int'(seq_fault), 1);
    wr(12'h000, 8'hF0);
    enter(8'h60); leave();
    chk("R1 password mode enter and exit", int'(seq_fault), 0);
    enter(8'hE0); wr(12'h000, 8'h90); wr(12'h000, 8'h11);
    chk("R8 bad exit second write faults", int'(seq_fault), 1);
    wr(12'h000, 8'hF0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h70);
    chk("R1 unknown mode code faults", int'(seq_fault), 1);
    wr(12'h000, 8'hF0);
    wr(12'h554, 8'hAA);
    chk("R11 wrong command address faults", int'(seq_fault), 1);
    wr(12'h000, 8'hF0);

    hw_reset();
    chk("R13 hardware reset clears bits", int'(sector_protected), 0);
    enter(8'hC0);
    wr(12'h000, 8'hA0); wr(sa(6, 9'h000), 8'h00);
    chk("R6 lock cleared by hardware reset", int'(sector_protected), 8'h40);
    leave();

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule